// File: doc/BRIEF.md
# External Interrupt Request Flag Register

This block turns six external, active-low interrupt request lines into sticky status flags. Each line has its own sense-control input. In level mode a flag is set for as long as the line is low. In falling-edge mode a flag is set once, on a high-to-low transition. Each pin passes through a two-stage synchroniser before any detection takes place.

Software sees the flags through one byte-wide register. Bits 5..0 hold the flags for lines 5..0, and bits 7..6 always read zero. Software can clear a flag but cannot set one. A zero written to a flag bit clears it only if that bit was read as one since the previous write. The interrupt core also clears a flag when it reports, with a one-cycle one-hot acknowledge pulse, that exception handling for the line has been carried out. In level mode this clear happens only while the pin is high; in edge mode it happens at any pin level. A combined request output gathers the flags whose per-line enable is high.

Top module: `ext_irq_flags`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data reads 0x00 and irq_req is low.
- R2: While standby is high at a clock edge, every flag is cleared and every read arm is dropped.
- R3: Bits 7 and 6 of rd_data always read 0. Writing ones to them changes nothing.
- R4: A write with bit n equal to 0 clears flag n when a read (rd_en high) was made while flag n was 1, with no write in between.
- R5: A write of 0 to bit n leaves flag n set when no arming read came before it. Any write consumes the arm of every bit, so a second write of 0 without a new read also has no effect.
- R6: Writing 1 to a flag bit never sets the flag.
- R7: With sense_edge[n]=0 (level), flag n is set while irq_n[n] is low. It is visible three clock edges after the pin falls, and it stays set after the pin returns high.
- R8: With sense_edge[n]=1 (falling edge), flag n is set only on a high-to-low transition of the synchronised pin. A pin that stays low does not set the flag again after it has been cleared.
- R9: In level mode, ack[n] clears flag n only when the synchronised pin n is high.
- R10: In edge mode, ack[n] clears flag n whatever the pin level.
- R11: When a set condition and a clear condition for the same flag occur in the same cycle, the flag ends up set.
- R12: irq_req is high exactly when some flag n is set and its irq_en[n] is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby | input | 1 | Hardware standby; clears all flags while high |
| irq_n | input | 6 | External request pins, active low, asynchronous |
| sense_edge | input | 6 | Per line: 0 = level sensed, 1 = falling-edge sensed |
| irq_en | input | 6 | Per-line enable for the combined request |
| ack | input | 6 | One-hot, one-cycle pulse: exception handling done for a line |
| rd_en | input | 1 | Register read strobe; arms the bits currently set |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; zero bits request a clear |
| rd_data | output | 8 | Register read value |
| flags | output | 6 | Current flag state |
| irq_req | output | 1 | Combined enabled request |

## Verification
The hardest case to reach from the ports is a software clear and a new edge-mode set landing on the same clock edge. The bench first sets and arms the flag. It then returns the pin high and lets it settle. Next it drives a new falling edge and asserts the zero write exactly two edges later, so that the write and the synchronised edge meet at the third edge. The bench also checks the arm-consumption rule: a read, then a write of all ones, then a write of zero, which must leave the flag standing.

// File: rtl/ext_irq_pkg.sv
// Package: shared sizes and the sense-mode encoding for the external
// interrupt flag register.
package ext_irq_pkg;
    localparam int unsigned N_LINES_DEF = 6;
    localparam int unsigned REG_W_DEF   = 8;
    localparam int unsigned SYNC_DEF    = 2;

    typedef enum logic {
        SENSE_LEVEL = 1'b0,
        SENSE_FALL  = 1'b1
    } sense_e;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// A chain of STAGES flops that brings one asynchronous pin into the clock
// domain. Assumes STAGES >= 1. Resets to RST_VAL so that an idle pin (high)
// does not look like an edge after reset.
module irq_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // First stage samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= RST_VAL;
                    else        chain[0] <= pin_async;
                end
            end else begin : g_next
                // Later stages shift the sample along
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
// Module: irq_detect
// Turns one synchronised active-low pin into a set request. In level mode
// the request follows the low level. In falling-edge mode it pulses for one
// cycle when the previous sample was high and the current one is low.
// Assumes pin_s is already synchronous to clk.
module irq_detect
    import ext_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   pin_s,
    input  sense_e sense,
    output logic   set_req,
    output logic   pin_high
);
    logic prev_s;

    // Keep the previous synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_s <= 1'b1;
        else        prev_s <= pin_s;
    end

    // Select the set condition for the configured sense mode
    always_comb begin
        if (sense == SENSE_FALL) set_req = prev_s & ~pin_s;
        else                     set_req = ~pin_s;
    end

    assign pin_high = pin_s;

    assert_fall_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sense == SENSE_FALL && $past(sense) == SENSE_FALL && !pin_s && !$past(pin_s)) |-> !set_req)
        else $error("edge mode raised a set with the pin held low");
endmodule

// File: rtl/irq_flag_cell.sv
// Module: irq_flag_cell
// One sticky flag with its read-before-clear arm. Set has priority over
// every clear. The arm is taken by a read while the flag is 1 and dropped
// by any write, by standby or when the flag is 0. Assumes ack is a
// single-cycle pulse.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_req,
    input  logic ack,
    input  logic ack_ok,
    input  logic rd_en,
    input  logic wr_en,
    input  logic wr_bit,
    output logic flag
);
    logic arm;
    logic sw_clr;
    logic ack_clr;

    assign sw_clr  = wr_en & ~wr_bit & arm;
    assign ack_clr = ack & ack_ok;

    // Flag update: standby, then set, then any clear
    always_ff @(posedge clk) begin
        if (!rst_n)                 flag <= 1'b0;
        else if (standby)           flag <= 1'b0;
        else if (set_req)           flag <= 1'b1;
        else if (sw_clr || ack_clr) flag <= 1'b0;
    end

    // Arm tracks a read of this bit as 1 since the last write
    always_ff @(posedge clk) begin
        if (!rst_n)                          arm <= 1'b0;
        else if (standby || wr_en || !flag)  arm <= 1'b0;
        else if (rd_en)                      arm <= 1'b1;
    end

    assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req && !standby) |=> flag)
        else $error("set lost against a clear");
    assert_no_write_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_req) |=> !flag)
        else $error("flag rose without a set condition");
    assert_unarmed_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !arm && !standby && !ack_clr) |=> flag)
        else $error("flag cleared without an arming read");
    // R9 and R10: a permitted acknowledge without a set clears the flag
    assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ack_ok && !set_req) |=> !flag)
        else $error("acknowledge failed to clear");
endmodule

// File: rtl/ext_irq_flags.sv
// Module: ext_irq_flags (top)
// Six external request lines -> synchroniser -> detector -> sticky flag
// cell. Exposes a byte register with zero reserved bits and a combined
// enabled request. Assumes ack is one-hot and lasts one cycle, and that
// rd_en/wr_en are single-cycle bus strobes.
module ext_irq_flags
    import ext_irq_pkg::*;
#(
    parameter int unsigned N_LINES = N_LINES_DEF,
    parameter int unsigned REG_W   = REG_W_DEF,
    parameter int unsigned SYNC_N  = SYNC_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               standby,
    input  logic [N_LINES-1:0] irq_n,
    input  logic [N_LINES-1:0] sense_edge,
    input  logic [N_LINES-1:0] irq_en,
    input  logic [N_LINES-1:0] ack,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    output logic [N_LINES-1:0] flags,
    output logic               irq_req
);
    localparam int unsigned RSV_W = REG_W - N_LINES;

    logic [N_LINES-1:0] pin_s;
    logic [N_LINES-1:0] set_req;
    logic [N_LINES-1:0] pin_high;

    genvar n;
    generate
        for (n = 0; n < N_LINES; n++) begin : g_line
            sense_e     mode;
            logic       ack_ok;

            assign mode   = sense_e'(sense_edge[n]);
            // Edge mode clears at any level; level mode needs the pin high
            assign ack_ok = (mode == SENSE_FALL) | pin_high[n];

            irq_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
                .clk       (clk),
                .rst_n     (rst_n),
                .pin_async (irq_n[n]),
                .pin_sync  (pin_s[n])
            );

            irq_detect u_det (
                .clk      (clk),
                .rst_n    (rst_n),
                .pin_s    (pin_s[n]),
                .sense    (mode),
                .set_req  (set_req[n]),
                .pin_high (pin_high[n])
            );

            irq_flag_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .standby (standby),
                .set_req (set_req[n]),
                .ack     (ack[n]),
                .ack_ok  (ack_ok),
                .rd_en   (rd_en),
                .wr_en   (wr_en),
                .wr_bit  (wr_data[n]),
                .flag    (flags[n])
            );
        end
    endgenerate

    assign rd_data = {{RSV_W{1'b0}}, flags};
    assign irq_req = |(flags & irq_en);

    assert_standby_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (flags == '0))
        else $error("standby left a flag set");
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0))
        else $error("reset left a flag set");
    assert_ack_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ack))
        else $error("acknowledge is not one-hot");
endmodule

// File: tb/ext_irq_flags_tb.sv
// Scoreboard bench: the driver pushes expected register/request values into
// a queue, and the monitor pops each item and compares it with the outputs.
module ext_irq_flags_tb;
    localparam int N = 6;
    localparam int W = 8;

    typedef struct {
        string      tag;
        logic [7:0] exp_rd;
        logic       exp_req;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         standby = 1'b0;
    logic [N-1:0] irq_n = '1;
    logic [N-1:0] sense_edge = '0;
    logic [N-1:0] irq_en = '0;
    logic [N-1:0] ack = '0;
    logic         rd_en = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '1;
    logic [W-1:0] rd_data;
    logic [N-1:0] flags;
    logic         irq_req;

    int    checks = 0;
    int    errors = 0;
    item_t sb_q[$];
    event  sample_ev;
    bit    done = 1'b0;

    always #4 clk = ~clk;

    ext_irq_flags u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .irq_n(irq_n),
        .sense_edge(sense_edge), .irq_en(irq_en), .ack(ack),
        .rd_en(rd_en), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .flags(flags), .irq_req(irq_req)
    );

    // Monitor: pop expectations and compare them with the outputs
    initial begin
        forever begin
            @(sample_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (rd_data !== it.exp_rd || irq_req !== it.exp_req) begin
                    errors++;
                    $display("FAIL %s: rd_data=%h req=%b expected rd_data=%h req=%b",
                             it.tag, rd_data, irq_req, it.exp_rd, it.exp_req);
                end
            end
        end
    end

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic expect_state(input string tag, input logic [7:0] e, input logic r);
        item_t it;
        it.tag = tag; it.exp_rd = e; it.exp_req = r;
        sb_q.push_back(it);
        -> sample_ev;
        #1;
    endtask

    task automatic do_read();
        rd_en = 1'b1; cyc(1); rd_en = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; cyc(1); wr_en = 1'b0; wr_data = '1;
    endtask

    task automatic pulse_ack(input int line);
        ack = '0; ack[line] = 1'b1; cyc(1); ack = '0;
    endtask

    // Driver: stimulus and expectations
    initial begin
        cyc(3);
        expect_state("R1 reset value", 8'h00, 1'b0);
        rst_n = 1'b1;
        cyc(2);

        // R3/R6: writing ones sets nothing, reserved bits stay zero
        do_write(8'hFF);
        expect_state("R3 R6 write ones", 8'h00, 1'b0);

        // R7: level line 0
        irq_n[0] = 1'b0; cyc(2);
        expect_state("R7 not yet after two edges", 8'h00, 1'b0);
        cyc(1);
        expect_state("R7 level set", 8'h01, 1'b0);
        irq_n[0] = 1'b1; cyc(4);
        expect_state("R7 sticky after pin high", 8'h01, 1'b0);

        // R5: write zero without a read
        do_write(8'h00);
        expect_state("R5 unarmed write", 8'h01, 1'b0);
        do_read(); do_write(8'hFF); do_write(8'h00);
        expect_state("R5 arm consumed", 8'h01, 1'b0);
        // R4: read then write zero to bit 0
        do_read(); do_write(8'hFE);
        expect_state("R4 armed clear", 8'h00, 1'b0);

        // R8/R10: edge line 1
        sense_edge[1] = 1'b1; cyc(3);
        irq_n[1] = 1'b0; cyc(3);
        expect_state("R8 falling edge set", 8'h02, 1'b0);
        pulse_ack(1);
        expect_state("R10 edge ack while low", 8'h00, 1'b0);
        cyc(4);
        expect_state("R8 held low no re-set", 8'h00, 1'b0);
        irq_n[1] = 1'b1; cyc(4);

        // R9: level line 2
        irq_n[2] = 1'b0; cyc(3);
        expect_state("R9 level set", 8'h04, 1'b0);
        pulse_ack(2);
        expect_state("R9 ack while low keeps flag", 8'h04, 1'b0);
        irq_n[2] = 1'b1; cyc(3);
        pulse_ack(2);
        expect_state("R9 ack while high clears", 8'h00, 1'b0);

        // R11: edge line 3, armed clear meets a new edge
        sense_edge[3] = 1'b1; cyc(3);
        irq_n[3] = 1'b0; cyc(3);
        expect_state("R11 first edge", 8'h08, 1'b0);
        do_read();
        irq_n[3] = 1'b1; cyc(4);
        irq_n[3] = 1'b0; cyc(2);
        do_write(8'h00);
        expect_state("R11 set beats clear", 8'h08, 1'b0);
        pulse_ack(3);
        irq_n[3] = 1'b1; cyc(4);
        expect_state("R10 cleared before next part", 8'h00, 1'b0);

        // R12: combined request, line 4 level
        irq_n[4] = 1'b0; cyc(3);
        irq_n[4] = 1'b1;
        expect_state("R12 flag without enable", 8'h10, 1'b0);
        irq_en = 6'b010000; #1;
        expect_state("R12 flag with enable", 8'h10, 1'b1);
        irq_en = 6'b101111; #1;
        expect_state("R12 other enables only", 8'h10, 1'b0);
        cyc(4);

        // R2: standby clears a set
        irq_n[5] = 1'b0; cyc(3); irq_n[5] = 1'b1; cyc(3);
        expect_state("R2 before standby", 8'h30, 1'b1);
        standby = 1'b1; cyc(1); standby = 1'b0;
        expect_state("R2 standby clears", 8'h00, 1'b0);

        cyc(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule